// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a clocked, register-based model of a burst static memory with registered read data. Every word is four 9-bit lanes, 36 bits in total. The array depth is set by an address-width parameter. On every rising clock edge the block decodes several inputs: three chip-select terms, two cycle-start strobes, a burst-advance input and the write controls. From these it classifies the edge as one of four kinds: a deselect, a new access, a burst continuation, or no operation.

A new access loads an external base address. Later edges either step a two-bit burst counter or hold it. The counter produces four addresses, in linear or interleaved order, and then wraps back to the first. Read data for the address used on edge N is loaded into an output register on edge N+1. The output drivers are modelled as a data port plus a drive flag. The drive flag is gated asynchronously by the output-enable input and by the sleep input.

A sleep input stops all internal state changes. The array contents are kept while it is asserted. The block is meant to sit behind a cache or a processor-side controller that generates the strobe protocol.

Top module: `burst_sram_core`

## Requirements
- R1: The device counts as selected on an edge only when `en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. An edge with `ctrl_start_n`=0, or with `proc_start_n`=0 and `en_n`=0, while the device is not selected, is a deselect. A deselect writes nothing, ends any burst, and leaves `rdata_oe`=0 after the next edge. `proc_start_n` has no effect while `en_n`=1.
- R2: A cycle started through `proc_start_n` is always a read. On that edge `gwr_n`, `bwr_en_n`, `bsel_n` and `wdata` leave the array unchanged.
- R3: A cycle started through `ctrl_start_n` is a write when `gwr_n`=0, or when `bwr_en_n`=0 and at least one `bsel_n` bit is 0. Otherwise it is a read.
- R4: `gwr_n`=0 writes all four lanes, whatever `bwr_en_n` and `bsel_n` hold. When `bwr_en_n`=1, `bsel_n` is ignored.
- R5: Lane k is word bits [9k+8:9k], and it is written when `bsel_n[k]`=0. Any mix of lanes can be written on one edge.
- R6: The word read on edge N appears on `rdata`, with `rdata_oe`=1, after edge N+1.
- R7: On an edge with both strobes inactive and `adv_n`=0, the burst counter steps. The address low two bits are base+count mod 4 when `ilv_mode`=0, and base XOR count when `ilv_mode`=1. The fifth address of a burst equals the first.
- R8: On a continuing edge with `adv_n`=1, the address of the previous edge is used again, for reads and for writes.
- R9: A write on edge N leaves `rdata_oe`=0 after that edge. `oe_n`=1 forces `rdata_oe`=0 and `rdata`=0 without waiting for a clock edge.
- R10: While `sleep`=1, no edge changes the array or the access state, and `rdata_oe` is 0 without waiting for a clock edge.
- R11: After reset the device is idle and deselected, with `rdata_oe`=0 and `rdata`=0.
- R12: Continuing edges that arrive while no access is active do nothing, even with the write controls asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Freezes all state; drive flag off |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| en_n | input | 1 | Enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Select term, active high |
| sel_lo_n | input | 1 | Select term, active low |
| proc_start_n | input | 1 | Processor-side start strobe, always a read |
| ctrl_start_n | input | 1 | Controller-side start strobe, read or write |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_en_n | input | 1 | Lane write gate, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read data, 0 when not driven |
| rdata_oe | output | 1 | Output drive flag |

## Verification
The bench fills the whole array, then reads every word back with back-to-back processor-start cycles while holding the write controls active. A design that let the processor strobe write would return the inverted data, and a design with the wrong pipeline depth would return the neighbouring word. It tries all sixteen lane masks and both lane-gating override cases, which exposes swapped lane positions and a byte gate that is not blocked. It runs bursts from each of the four start offsets in both orders, including the wrap on the fifth access, and mixes suspended and advancing bursts for both reads and writes. This catches sequencers that add where they should XOR, or that advance on a suspend. Deselect cycles, ungated processor strobes, write-time output blanking and sleep with write attempts are each checked, so that a stray write or a driven output shows up at the ports.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    // default geometry of the core
    localparam int DEF_ADDR_W  = 6;
    localparam int DEF_LANES   = 4;
    localparam int DEF_LANE_W  = 9;
    localparam int DEF_BURST_W = 2;

    // classification of one clock edge
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_DESEL = 2'd1,
        ACT_START = 2'd2,
        ACT_CONT  = 2'd3
    } act_e;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int LANES   = DEF_LANES,
    parameter int BURST_W = DEF_BURST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ilv_mode,
    input  logic              en_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              proc_start_n,
    input  logic              ctrl_start_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_en_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [LANES-1:0]  wr_lanes,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] cyc_addr_q,
    output logic              cyc_rd_q,
    output logic              drv_q
);
    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [BURST_W-1:0] cnt;
        logic [ADDR_W-1:0] cyc_addr;
        logic              cyc_rd;
        logic              drv;
    } st_t;

    st_t  st_q, st_d;
    act_e act;
    logic selected, p_go, c_go, wr_req, cyc_rd;
    logic [LANES-1:0] lanes_req;

    function automatic logic [ADDR_W-1:0] burst_addr(
        input logic              ilv,
        input logic [ADDR_W-1:0] b,
        input logic [BURST_W-1:0] c
    );
        logic [BURST_W-1:0] lo;
        lo = ilv ? (b[BURST_W-1:0] ^ c) : (b[BURST_W-1:0] + c);
        return {b[ADDR_W-1:BURST_W], lo};
    endfunction

    always_comb begin
        st_d      = st_q;
        selected  = !en_n && sel_hi && !sel_lo_n;
        p_go      = !proc_start_n && !en_n;
        c_go      = !ctrl_start_n;
        wr_req    = !gwr_n || (!bwr_en_n && (|(~bsel_n)));
        lanes_req = !gwr_n ? '1 : (bwr_en_n ? '0 : ~bsel_n);
        wr_en     = 1'b0;
        wr_lanes  = '0;
        eff_addr  = burst_addr(ilv_mode, st_q.base, st_q.cnt);

        if (p_go || c_go)
            act = selected ? ACT_START : ACT_DESEL;
        else if (st_q.active)
            act = ACT_CONT;
        else
            act = ACT_NONE;

        case (act)
            ACT_DESEL: begin
                st_d.active = 1'b0;
            end
            ACT_START: begin
                st_d.active = 1'b1;
                st_d.base   = addr;
                st_d.cnt    = '0;
                eff_addr    = addr;
                if (!p_go && wr_req) begin
                    wr_en    = 1'b1;
                    wr_lanes = lanes_req;
                end
            end
            ACT_CONT: begin
                if (!adv_n)
                    st_d.cnt = st_q.cnt + 1'b1;
                eff_addr = burst_addr(ilv_mode, st_q.base, st_d.cnt);
                if (wr_req) begin
                    wr_en    = 1'b1;
                    wr_lanes = lanes_req;
                end
            end
            default: ;
        endcase

        cyc_rd        = ((act == ACT_START) || (act == ACT_CONT)) && !wr_en;
        st_d.cyc_addr = eff_addr;
        st_d.cyc_rd   = cyc_rd;
        st_d.drv      = st_q.cyc_rd && !wr_en;

        if (!run) begin
            st_d     = st_q;
            wr_en    = 1'b0;
            wr_lanes = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_addr_q = st_q.cyc_addr;
    assign cyc_rd_q   = st_q.cyc_rd;
    assign drv_q      = st_q.drv;

    // R2
    proc_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && !en_n) |-> !wr_en);

    // R1
    desel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!en_n && sel_hi && !sel_lo_n) && (!ctrl_start_n || (!proc_start_n && !en_n)))
        |-> !wr_en);

    // R4
    gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !gwr_n) |-> (wr_lanes == '1));

    // R9
    write_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en) |=> !drv_q);

    // R10
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(st_q.cnt) && $stable(st_q.active) && $stable(st_q.base)));
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] rdata_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];
        always_ff @(posedge clk) begin
            if (run && wr_en && wr_lanes[g])
                mem_l[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rd_word[g*LANE_W +: LANE_W] = mem_l[rd_addr];
    end

    always_comb begin
        rdata_d = rdata_q;
        if (run && rd_en)
            rdata_d = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    // R5
    lanes_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_lanes != '0));
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import bsram_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int LANES   = DEF_LANES,
    parameter int LANE_W  = DEF_LANE_W,
    parameter int BURST_W = DEF_BURST_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    ilv_mode,
    input  logic                    en_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    proc_start_n,
    input  logic                    ctrl_start_n,
    input  logic                    adv_n,
    input  logic                    gwr_n,
    input  logic                    bwr_en_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int WORD_W = LANES * LANE_W;

    logic              run;
    logic              wr_en, cyc_rd_q, drv_q;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] eff_addr, cyc_addr_q;
    logic [WORD_W-1:0] rdata_q;

    assign run = !sleep;

    bsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .ilv_mode(ilv_mode),
        .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
        .adv_n(adv_n), .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .bsel_n(bsel_n),
        .addr(addr), .wr_en(wr_en), .wr_lanes(wr_lanes), .eff_addr(eff_addr),
        .cyc_addr_q(cyc_addr_q), .cyc_rd_q(cyc_rd_q), .drv_q(drv_q)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_lanes(wr_lanes),
        .wr_addr(eff_addr), .wdata(wdata), .rd_en(cyc_rd_q), .rd_addr(cyc_addr_q),
        .rdata_q(rdata_q)
    );

    assign rdata_oe = drv_q && !oe_n && !sleep;
    assign rdata    = rdata_oe ? rdata_q : '0;

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || sleep) |-> (!rdata_oe && (rdata == '0)));
endmodule

// File: tb/sim_burst_sram_core.sv
module sim_burst_sram_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0, ilv_mode = 1'b0;
    logic        en_n, sel_hi, sel_lo_n, proc_start_n, ctrl_start_n, adv_n;
    logic        gwr_n, bwr_en_n, oe_n;
    logic [3:0]  bsel_n;
    logic [5:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_oe;

    logic [35:0] rm [64];
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    burst_sram_core u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ilv_mode(ilv_mode),
        .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .bsel_n(bsel_n), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [35:0] pat(input int a);
        return 36'(a) * 36'h1_3579_BDF1 + 36'h2_468A;
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [35:0] exp);
        chk(req, {35'd0, rdata_oe}, 36'd1);
        chk(req, rdata, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        en_n = 1'b1; sel_hi = 1'b0; sel_lo_n = 1'b1;
        proc_start_n = 1'b1; ctrl_start_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_en_n = 1'b1; bsel_n = 4'hF; oe_n = 1'b0;
    endtask

    task automatic sel_on();
        en_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    endtask

    task automatic pstart(input int a);
        idle_in(); sel_on(); proc_start_n = 1'b0; addr = 6'(a);
    endtask

    task automatic cstart_wr(input int a, input logic [35:0] d);
        idle_in(); sel_on(); ctrl_start_n = 1'b0; addr = 6'(a);
        gwr_n = 1'b0; wdata = d;
    endtask

    task automatic read_one(input string req, input int a);
        pstart(a); step();
        idle_in(); step();
        chk_rd(req, rm[a]);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        idle_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle after reset
        chk("R11", {35'd0, rdata_oe}, 36'd0);
        chk("R11", rdata, 36'd0);

        // R3 fill every word with controller-start global writes
        for (int a = 0; a < 64; a++) begin
            cstart_wr(a, pat(a)); step();
            rm[a] = pat(a);
        end

        // R2 R6: back-to-back processor starts with write controls held active
        for (int a = 0; a < 64; a++) begin
            pstart(a); gwr_n = 1'b0; bwr_en_n = 1'b0; bsel_n = 4'h0; wdata = ~pat(a);
            step();
            if (a > 0) chk_rd("R2 R6", rm[a-1]);
        end
        idle_in(); step();
        chk_rd("R6", rm[63]);

        // R5 R3: every lane mask
        for (int m = 0; m < 16; m++) begin
            logic [3:0]  ml;
            logic [35:0] v;
            ml = 4'(m);
            v  = pat(m + 100);
            idle_in(); sel_on(); ctrl_start_n = 1'b0; addr = 6'd5;
            bwr_en_n = 1'b0; bsel_n = ~ml; wdata = v;
            step();
            for (int l = 0; l < 4; l++)
                if (ml[l]) rm[5][l*9 +: 9] = v[l*9 +: 9];
            read_one("R5", 5);
        end

        // R4: lane gate off blocks selects, the cycle is a read
        idle_in(); sel_on(); ctrl_start_n = 1'b0; addr = 6'd6;
        bwr_en_n = 1'b1; bsel_n = 4'h0; wdata = 36'hF_FFFF_FFFF;
        step();
        idle_in(); step();
        chk_rd("R4", rm[6]);
        // R4: global write overrides a single-lane selection
        idle_in(); sel_on(); ctrl_start_n = 1'b0; addr = 6'd6;
        gwr_n = 1'b0; bwr_en_n = 1'b0; bsel_n = 4'b1110; wdata = 36'hA_5A5A_5A5A;
        step();
        rm[6] = 36'hA_5A5A_5A5A;
        read_one("R4", 6);

        // R7: bursts from every offset in both orders, with wrap
        for (int ilv = 0; ilv < 2; ilv++) begin
            ilv_mode = ilv[0];
            for (int b = 0; b < 4; b++) begin
                pstart(16 + b); step();
                for (int k = 1; k <= 5; k++) begin
                    int j, ea;
                    idle_in(); adv_n = 1'b0; step();
                    j  = (k - 1) % 4;
                    ea = 16 + ((ilv == 1) ? (b ^ j) : ((b + j) % 4));
                    chk_rd("R7", rm[ea]);
                end
            end
        end
        ilv_mode = 1'b0;

        // R8: suspended read burst
        pstart(20); step();
        idle_in(); step();               chk_rd("R8", rm[20]);
        idle_in(); step();               chk_rd("R8", rm[20]);
        idle_in(); adv_n = 1'b0; step(); chk_rd("R8", rm[20]);
        idle_in(); step();               chk_rd("R8", rm[21]);

        // R8: write burst with a suspend overwriting the same word
        cstart_wr(40, 36'h1_1111_1111); step(); rm[40] = 36'h1_1111_1111;
        idle_in(); adv_n = 1'b0; gwr_n = 1'b0; wdata = 36'h2_2222_2222; step(); rm[41] = 36'h2_2222_2222;
        idle_in(); gwr_n = 1'b0; wdata = 36'h3_3333_3333; step(); rm[41] = 36'h3_3333_3333;
        idle_in(); adv_n = 1'b0; gwr_n = 1'b0; wdata = 36'h4_4444_4444; step(); rm[42] = 36'h4_4444_4444;
        for (int a = 40; a < 44; a++) read_one("R8", a);

        // R9: a write blanks the pending read
        pstart(50); step();
        idle_in(); gwr_n = 1'b0; wdata = 36'h5_0505_0505; step();
        rm[50] = 36'h5_0505_0505;
        chk("R9", {35'd0, rdata_oe}, 36'd0);
        idle_in(); step();
        idle_in(); step();
        chk_rd("R9", rm[50]);
        oe_n = 1'b1; #1;
        chk("R9", {35'd0, rdata_oe}, 36'd0);
        chk("R9", rdata, 36'd0);
        oe_n = 1'b0; #1;
        chk_rd("R9", rm[50]);

        // R1: controller start without select is a deselect
        idle_in(); en_n = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b0; ctrl_start_n = 1'b0;
        gwr_n = 1'b0; addr = 6'd7; wdata = 36'h0; step();
        // R12: continue edges while inactive do nothing
        idle_in(); adv_n = 1'b0; gwr_n = 1'b0; wdata = 36'h0; step();
        chk("R12", {35'd0, rdata_oe}, 36'd0);
        idle_in(); gwr_n = 1'b0; wdata = 36'h0; step();
        chk("R1", {35'd0, rdata_oe}, 36'd0);
        read_one("R1 R12", 7);
        // R1: processor strobe with en_n high only continues the burst
        pstart(30); step();
        idle_in(); proc_start_n = 1'b0; adv_n = 1'b0; addr = 6'd3; step();
        chk_rd("R1", rm[30]);
        idle_in(); step();
        chk_rd("R1", rm[31]);

        // R10: sleep blanks outputs and freezes the array
        pstart(9); step();
        idle_in(); step();
        chk_rd("R10", rm[9]);
        sleep = 1'b1; #1;
        chk("R10", {35'd0, rdata_oe}, 36'd0);
        cstart_wr(9, 36'h0); step();
        cstart_wr(9, 36'h0); step();
        chk("R10", {35'd0, rdata_oe}, 36'd0);
        sleep = 1'b0;
        idle_in(); en_n = 1'b0; proc_start_n = 1'b0; step();
        read_one("R10", 9);

        summary();
        $finish;
    end
endmodule